// File: doc/BRIEF.md
# Flash Page Protection Gate

This block sits between a flash controller's command port and the flash array. Each cycle it may receive one command: a word write, a page erase or a whole-array erase. It decides whether the command may reach the array. Permitted commands go out to the array one cycle later. Refused commands never reach the array. Instead they produce a reject pulse and set a sticky abort flag. Software clears that flag by writing a one to it.

The decision rests on a 128-bit protection image. The image is copied word by word from the reserved top 16 bytes of the highest page into a shadow register after reset. The shadow comes out of reset as all ones. That is the erased state, in which every page is open.

Protection bits are active low. Bit p guards page p. The highest page holds the image itself, so it has no bit of its own: it is locked whenever the device is outside debug mode. Bit 127 is the debug-lock bit. When it reads zero, the block tells the debug interface to ignore most of its commands. Page size is selectable between 1 KB and 2 KB. The selection changes how an address maps to a page index and which page is the highest.

Top module: `flash_lock_gate`

## Requirements
- R1: After reset, `arr_req`, `cmd_reject`, `abort_flag` and `dbg_ignore` are 0, and the shadow image is all ones, so every page below the highest is open.
- R2: The page index is `cmd_addr >> 10` when `cfg_page_2k` is 0 and `cmd_addr >> 11` when it is 1. The highest page is the largest index the address width allows in that mode.
- R3: Asserting `lock_wr_en` writes `lock_wr_data` into bits 32*`lock_wr_idx` to 32*`lock_wr_idx`+31 of the image. The new bits decide commands presented from the next cycle on.
- R4: A write (`cmd_op`=1) or page erase (`cmd_op`=2) to a page below the highest is rejected when that page's image bit is 0 and granted when it is 1.
- R5: A write or page erase to the highest page is rejected when `debug_mode` is 0 and granted when it is 1, whatever the image holds.
- R6: A whole-array erase (`cmd_op`=3) is granted when `debug_mode` is 1. Otherwise it is rejected if any image bit for a page below the highest is 0. Image bits at or above the highest page index play no part.
- R7: `dbg_ignore` is 1 exactly when image bit 127 (the debug-lock bit) is 0.
- R8: A command with `cmd_valid` high and a non-zero op yields, one cycle later, either `arr_req` or `cmd_reject` (never both). On `arr_req`, `arr_op` and `arr_addr` carry the command. Op 0 (no operation) or `cmd_valid` low yields neither.
- R9: `abort_flag` is set by every rejection and holds until a cycle with `abort_clr` high. When a rejection and a clear coincide, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_page_2k | input | 1 | 1 selects 2 KB pages, 0 selects 1 KB pages |
| debug_mode | input | 1 | Debug mode active |
| lock_wr_en | input | 1 | Load one 32-bit word of the protection image |
| lock_wr_idx | input | 2 | Image word index |
| lock_wr_data | input | 32 | Image word contents |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 none, 1 write, 2 page erase, 3 whole-array erase |
| cmd_addr | input | ADDR_W | Byte address of the command |
| abort_clr | input | 1 | Write-one-to-clear for the abort flag |
| arr_req | output | 1 | Granted command issued to the array |
| arr_op | output | 2 | Op of the issued command |
| arr_addr | output | ADDR_W | Address of the issued command |
| cmd_reject | output | 1 | Command refused |
| abort_flag | output | 1 | Sticky record of a refusal |
| dbg_ignore | output | 1 | Debug interface should ignore most commands |

## Verification
The bench builds the block with ADDR_W of 15, a 32 KB array. That gives 32 pages in 1 KB mode and 16 in 2 KB mode, so the same address falls on different pages as `cfg_page_2k` toggles. Both highest pages (31 and 15) lie inside the first image word. Image bits 15 to 30 count as protection in one mode and are ignored in the other, which lets the bench observe the masking in the whole-array erase decision. All four image words can be loaded, so the debug-lock bit at position 127 can be reached.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_PERASE = 2'd2,
        OP_MERASE = 2'd3
    } flk_op_e;

    localparam int IMG_WORD_W = 32;
    localparam int IMG_WORDS  = 4;
    localparam int IMG_BITS   = IMG_WORD_W * IMG_WORDS;
    localparam int DBG_BIT    = IMG_BITS - 1;
    localparam int SHIFT_1K   = 10;
    localparam int SHIFT_2K   = 11;

    typedef struct packed {
        logic grant;
        logic reject;
    } flk_verdict_t;

    function automatic flk_verdict_t make_verdict(logic present, flk_op_e op, logic locked);
        flk_verdict_t v;
        v.grant  = present && (op != OP_NONE) && !locked;
        v.reject = present && (op != OP_NONE) && locked;
        return v;
    endfunction

endpackage

// File: rtl/flk_shadow.sv
module flk_shadow
    import flk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_idx,
    input  logic [IMG_WORD_W-1:0] wr_data,
    output logic [IMG_BITS-1:0]   image
);
    for (genvar w = 0; w < IMG_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                image[w*IMG_WORD_W +: IMG_WORD_W] <= '1;
            else if (wr_en && (wr_idx == 2'(w)))
                image[w*IMG_WORD_W +: IMG_WORD_W] <= wr_data;
        end
    end
endmodule

// File: rtl/flk_decide.sv
module flk_decide
    import flk_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic                cmd_valid,
    input  flk_op_e             op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                cfg_page_2k,
    input  logic                debug_mode,
    input  logic [IMG_BITS-1:0] image,
    output flk_verdict_t        verdict
);
    localparam int PG_W = ADDR_W - SHIFT_1K;
    localparam int MAXP = 1 << PG_W;

    logic [PG_W-1:0] page;
    logic [PG_W-1:0] top;
    logic [MAXP-1:0] below;
    logic [MAXP-1:0] lock_lo;
    logic            any_locked;
    logic            locked;

    assign page = cfg_page_2k ? {1'b0, addr[ADDR_W-1:SHIFT_2K]} : addr[ADDR_W-1:SHIFT_1K];
    assign top  = cfg_page_2k ? {1'b0, {(PG_W-1){1'b1}}} : {PG_W{1'b1}};
    assign lock_lo = image[MAXP-1:0];

    for (genvar i = 0; i < MAXP; i++) begin : g_below
        assign below[i] = top > PG_W'(i);
    end

    assign any_locked = |(~lock_lo & below);

    always_comb begin
        locked = 1'b0;
        unique case (op)
            OP_WRITE, OP_PERASE:
                locked = (page == top) ? !debug_mode : !lock_lo[page];
            OP_MERASE:
                locked = !debug_mode && any_locked;
            default:
                locked = 1'b0;
        endcase
    end

    assign verdict = make_verdict(cmd_valid, op, locked);
endmodule

// File: rtl/flk_resp.sv
module flk_resp
    import flk_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  flk_verdict_t      verdict,
    input  flk_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              abort_clr,
    output logic              arr_req,
    output flk_op_e           arr_op,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              cmd_reject,
    output logic              abort_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            arr_req    <= 1'b0;
            cmd_reject <= 1'b0;
            abort_flag <= 1'b0;
            arr_op     <= OP_NONE;
            arr_addr   <= '0;
        end else begin
            arr_req    <= verdict.grant;
            cmd_reject <= verdict.reject;
            abort_flag <= verdict.reject || (abort_flag && !abort_clr);
            if (verdict.grant) begin
                arr_op   <= op;
                arr_addr <= addr;
            end
        end
    end
endmodule

// File: rtl/flash_lock_gate.sv
module flash_lock_gate
    import flk_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_page_2k,
    input  logic              debug_mode,
    input  logic              lock_wr_en,
    input  logic [1:0]        lock_wr_idx,
    input  logic [31:0]       lock_wr_data,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              abort_clr,
    output logic              arr_req,
    output logic [1:0]        arr_op,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              cmd_reject,
    output logic              abort_flag,
    output logic              dbg_ignore
);
    logic [IMG_BITS-1:0] image;
    flk_verdict_t        verdict;
    flk_op_e             op_in;
    flk_op_e             op_out;

    assign op_in  = flk_op_e'(cmd_op);
    assign arr_op = op_out;

    flk_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lock_wr_en),
        .wr_idx  (lock_wr_idx),
        .wr_data (lock_wr_data),
        .image   (image)
    );

    flk_decide #(.ADDR_W(ADDR_W)) u_decide (
        .cmd_valid   (cmd_valid),
        .op          (op_in),
        .addr        (cmd_addr),
        .cfg_page_2k (cfg_page_2k),
        .debug_mode  (debug_mode),
        .image       (image),
        .verdict     (verdict)
    );

    flk_resp #(.ADDR_W(ADDR_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .verdict    (verdict),
        .op         (op_in),
        .addr       (cmd_addr),
        .abort_clr  (abort_clr),
        .arr_req    (arr_req),
        .arr_op     (op_out),
        .arr_addr   (arr_addr),
        .cmd_reject (cmd_reject),
        .abort_flag (abort_flag)
    );

    assign dbg_ignore = !image[DBG_BIT];
endmodule

// File: rtl/flash_lock_gate_chk.sv
module flash_lock_gate_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_page_2k,
    input logic              debug_mode,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              abort_clr,
    input logic              arr_req,
    input logic              cmd_reject,
    input logic              abort_flag
);
    logic hits_top;
    assign hits_top = cfg_page_2k ? (cmd_addr[ADDR_W-1:11] == {(ADDR_W-11){1'b1}})
                                  : (cmd_addr[ADDR_W-1:10] == {(ADDR_W-10){1'b1}});

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        !(arr_req && cmd_reject));

    assert_cmd_answered_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op != 2'd0) |=> (arr_req || cmd_reject));

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd_op == 2'd0) |=> (!arr_req && !cmd_reject));

    assert_top_page_guard_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !debug_mode && hits_top && (cmd_op == 2'd1 || cmd_op == 2'd2)) |=> cmd_reject);

    assert_reject_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> abort_flag);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (abort_flag && !abort_clr) |=> abort_flag);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
        abort_clr |=> (cmd_reject || !abort_flag));
endmodule

bind flash_lock_gate flash_lock_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_page_2k (cfg_page_2k),
    .debug_mode  (debug_mode),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .abort_clr   (abort_clr),
    .arr_req     (arr_req),
    .cmd_reject  (cmd_reject),
    .abort_flag  (abort_flag)
);

// File: tb/sim_flash_lock_gate.sv
`timescale 1ns/1ps
module sim_flash_lock_gate;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_page_2k = 1'b0;
    logic          debug_mode = 1'b0;
    logic          lock_wr_en = 1'b0;
    logic [1:0]    lock_wr_idx = '0;
    logic [31:0]   lock_wr_data = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          abort_clr = 1'b0;
    logic          arr_req, cmd_reject, abort_flag, dbg_ignore;
    logic [1:0]    arr_op;
    logic [AW-1:0] arr_addr;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    flash_lock_gate #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cfg_page_2k(cfg_page_2k), .debug_mode(debug_mode),
        .lock_wr_en(lock_wr_en), .lock_wr_idx(lock_wr_idx), .lock_wr_data(lock_wr_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .abort_clr(abort_clr),
        .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr),
        .cmd_reject(cmd_reject), .abort_flag(abort_flag), .dbg_ignore(dbg_ignore)
    );

    // Behavioural reference model
    logic [127:0]  m_img;
    logic          m_gnt, m_rej, m_flag;
    logic [1:0]    m_op;
    logic [AW-1:0] m_addr;

    always @(posedge clk) begin
        int  sh, pg, top;
        bit  lk, any0;
        if (rst) begin
            m_img = '1; m_gnt = 0; m_rej = 0; m_flag = 0; m_op = 0; m_addr = 0;
        end else begin
            sh  = cfg_page_2k ? 11 : 10;
            pg  = int'(cmd_addr) >> sh;
            top = (1 << (AW - sh)) - 1;
            any0 = 0;
            for (int i = 0; i < top; i++) if (!m_img[i]) any0 = 1;
            lk = 0;
            if (cmd_op == 2'd3) lk = !debug_mode && any0;
            else if (pg == top) lk = !debug_mode;
            else lk = !m_img[pg];
            m_gnt = cmd_valid && cmd_op != 0 && !lk;
            m_rej = cmd_valid && cmd_op != 0 && lk;
            m_flag = m_rej || (m_flag && !abort_clr);
            if (m_gnt) begin m_op = cmd_op; m_addr = cmd_addr; end
            if (lock_wr_en) m_img[lock_wr_idx*32 +: 32] = lock_wr_data;
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk(cur_req, "arr_req", 64'(arr_req), 64'(m_gnt));
        chk(cur_req, "cmd_reject", 64'(cmd_reject), 64'(m_rej));
        chk("R9", "abort_flag", 64'(abort_flag), 64'(m_flag));
        chk("R7", "dbg_ignore", 64'(dbg_ignore), 64'(!m_img[127]));
        if (m_gnt) begin
            chk("R8", "arr_op", 64'(arr_op), 64'(m_op));
            chk("R8", "arr_addr", 64'(arr_addr), 64'(m_addr));
        end
        cmd_valid = 0; lock_wr_en = 0; abort_clr = 0;
    endtask

    task automatic cmd(logic [1:0] op, logic [AW-1:0] a);
        cmd_valid = 1; cmd_op = op; cmd_addr = a;
        cyc();
    endtask

    task automatic ldw(logic [1:0] idx, logic [31:0] d);
        lock_wr_en = 1; lock_wr_idx = idx; lock_wr_data = d;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state seen at the ports
        cur_req = "R1";
        chk("R1", "arr_req after reset", 64'(arr_req), 64'd0);
        chk("R1", "cmd_reject after reset", 64'(cmd_reject), 64'd0);
        chk("R1", "abort_flag after reset", 64'(abort_flag), 64'd0);
        chk("R1", "dbg_ignore after reset", 64'(dbg_ignore), 64'd0);
        cmd(2'd1, 15'h0c10);               // page 3 open after reset
        cmd(2'd3, 15'h0000);               // mass erase, all open
        // R3/R4: close page 3 and page 20
        cur_req = "R3";
        ldw(2'd0, ~32'h0010_0008);
        cmd(2'd1, 15'h0c10);
        cur_req = "R4";
        cmd(2'd2, 15'h0c00);
        cmd(2'd1, 15'h1000);               // page 4 open
        // R9: clear, then simultaneous reject and clear
        cur_req = "R9";
        abort_clr = 1; cyc();
        abort_clr = 1; cmd(2'd1, 15'h0c00);
        abort_clr = 1; cyc();
        // R8: no-op and invalid command
        cur_req = "R8";
        cmd(2'd0, 15'h0c00);
        cmd_op = 2'd1; cyc();
        // R5: highest page in 1 KB mode is 31
        cur_req = "R5";
        cmd(2'd1, 15'h7c00);
        debug_mode = 1; cmd(2'd2, 15'h7fff);
        debug_mode = 0;
        // R2: 2 KB pages; 0x1800 is page 3 (closed), in 1 KB it is page 6
        cur_req = "R2";
        cfg_page_2k = 1; cmd(2'd1, 15'h1800);
        cfg_page_2k = 0; cmd(2'd1, 15'h1800);
        cfg_page_2k = 1; cur_req = "R5"; cmd(2'd1, 15'h7800);
        // R6: masked bit 20 in 2 KB mode, bit 3 still closed
        cur_req = "R6";
        cmd(2'd3, 15'h0);
        debug_mode = 1; cmd(2'd3, 15'h0); debug_mode = 0;
        ldw(2'd0, ~32'h0010_0000);         // only bit 20 closed
        cmd(2'd3, 15'h0);                  // 2 KB: ignored, granted
        cfg_page_2k = 0; cmd(2'd3, 15'h0); // 1 KB: counted, rejected
        ldw(2'd0, 32'h7fff_ffff);          // bit 31 is the top page: no effect
        cmd(2'd3, 15'h0);
        // R7: debug-lock bit
        cur_req = "R7";
        ldw(2'd3, 32'h7fff_ffff);
        ldw(2'd3, 32'hffff_ffff);
        // random mix
        cur_req = "R4";
        for (int k = 0; k < 600; k++) begin
            cfg_page_2k = 1'($urandom);
            debug_mode  = ($urandom % 4) == 0;
            abort_clr   = ($urandom % 5) == 0;
            if (($urandom % 8) == 0) begin
                lock_wr_en = 1; lock_wr_idx = 2'($urandom);
                lock_wr_data = $urandom | $urandom | $urandom;
            end
            cmd_valid = ($urandom % 4) != 0;
            cmd_op = 2'($urandom);
            cmd_addr = AW'($urandom);
            cyc();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule